// File: doc/BRIEF.md
# Accumulator Operate Micro-Op Unit

This block executes the first group of micro-coded operate instructions for a 12-bit accumulator machine that carries a 1-bit link register beside the accumulator. One instruction word can ask for several small operations at once: zeroing, inverting, incrementing, rotating and half-swapping. The unit applies them in a fixed sequence to the current accumulator and link and returns the updated pair.

The unit also reports four dependency flags. They say whether the instruction reads the accumulator, writes the accumulator, reads the link or writes the link. A surrounding pipeline can use them for hazard detection and operand forwarding.

An outside opcode decoder selects this group and raises `in_valid` for one cycle with the instruction and operands. On the next clock the unit presents the results and the flags, and `done` is high for that cycle. The outputs keep their values until the next strobe. A synchronous reset clears every output.

Top module: `opr_micro_unit`

## Requirements
- R1: While reset is high, and on the clock after it, `out_acc`, `out_link`, all four flag outputs and `done` are zero.
- R2: Bit 7 zeroes the accumulator and bit 6 zeroes the link. Bit 5 inverts the accumulator and bit 4 inverts the link. Zeroing comes before inverting, so bits 7 and 5 set together give 12'o7777.
- R3: Bit 0 adds one to the accumulator, modulo 4096, after the zeroing and inverting steps. When the sum wraps to zero the link is inverted.
- R4: Bit 3 alone rotates the 13-bit value {link, accumulator} right by one place: accumulator bit 0 goes to the link and the old link goes to accumulator bit 11. Bit 2 alone rotates it left by one place. Rotation is the last step.
- R5: Bit 1 with neither rotate bit exchanges accumulator bits 11:6 with bits 5:0 and leaves the link unchanged.
- R6: Bit 1 with exactly one rotate bit set makes that rotation move two places.
- R7: With bits 3 and 2 both set, no rotation and no swap take place. Zeroing, inverting and incrementing still apply.
- R8: `rd_acc` = bit 5 | bit 3 | bit 2 | bit 1 | bit 0. `wr_acc` = `rd_acc` | bit 7. `rd_link` = bit 4 | bit 3 | bit 2 | bit 0. `wr_link` = `rd_link` | bit 6. An accumulator or link whose write flag is clear comes out equal to its input.
- R9: Results and flags are captured on a clock edge where `in_valid` is high. They appear, with `done` high, right after that edge. When `in_valid` is low, `done` falls and every other output holds.
- R10: Instruction bits 11:8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that qualifies the instruction and operands |
| in_instr | input | 12 | Instruction word; bits 7:0 hold the micro-op fields |
| in_acc | input | 12 | Current accumulator |
| in_link | input | 1 | Current link |
| done | output | 1 | High for one cycle after each accepted strobe |
| out_acc | output | 12 | Updated accumulator |
| out_link | output | 1 | Updated link |
| rd_acc | output | 1 | Instruction reads the accumulator |
| wr_acc | output | 1 | Instruction writes the accumulator |
| rd_link | output | 1 | Instruction reads the link |
| wr_link | output | 1 | Instruction writes the link |

## Verification
The assertions watch several rules on every cycle:
- `done` only follows a strobe.
- The outputs hold while the unit is idle.
- A read flag always implies the matching write flag.
- An operand whose write flag is clear passes through unchanged.
- Rotation and swapping preserve the number of one bits.
- An increment that wraps always inverts the link.

Only the bench's scenarios can show that the micro-ops are applied in the right order and give the exact values. The bench sweeps every combination of the eight field bits over a set of boundary operands and both link values, and compares each result with a reference computed arithmetically. Separate directed scenarios show that bits 11:8 are ignored.

// File: rtl/opr_micro_pkg.sv
package opr_micro_pkg;
  parameter int ACC_W  = 12;
  parameter int INSN_W = 12;
  localparam int HALF_W = ACC_W / 2;
  localparam int WIDE_W = ACC_W + 1;

  // micro-op field positions inside the instruction word
  localparam int B_ZERO_ACC  = 7;
  localparam int B_ZERO_LINK = 6;
  localparam int B_INV_ACC   = 5;
  localparam int B_INV_LINK  = 4;
  localparam int B_ROT_R     = 3;
  localparam int B_ROT_L     = 2;
  localparam int B_PAIR      = 1;
  localparam int B_BUMP      = 0;

  typedef struct packed {
    logic zero_acc;
    logic zero_link;
    logic inv_acc;
    logic inv_link;
    logic rot_r;
    logic rot_l;
    logic pair;
    logic bump;
  } micro_t;

  typedef struct packed {
    logic rd_acc;
    logic wr_acc;
    logic rd_link;
    logic wr_link;
  } hazard_t;
endpackage

// File: rtl/opr_field_decode.sv
module opr_field_decode
  import opr_micro_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output micro_t            ops,
  output hazard_t           haz
);
  logic unused_hi;
  assign unused_hi = ^instr[INSN_W-1:B_ZERO_ACC+1];

  always_comb begin
    ops.zero_acc  = instr[B_ZERO_ACC];
    ops.zero_link = instr[B_ZERO_LINK];
    ops.inv_acc   = instr[B_INV_ACC];
    ops.inv_link  = instr[B_INV_LINK];
    ops.rot_r     = instr[B_ROT_R];
    ops.rot_l     = instr[B_ROT_L];
    ops.pair      = instr[B_PAIR];
    ops.bump      = instr[B_BUMP];
  end

  always_comb begin
    haz.rd_acc  = ops.inv_acc | ops.rot_r | ops.rot_l | ops.pair | ops.bump;
    haz.wr_acc  = haz.rd_acc | ops.zero_acc;
    haz.rd_link = ops.inv_link | ops.rot_r | ops.rot_l | ops.bump;
    haz.wr_link = haz.rd_link | ops.zero_link;
  end
endmodule

// File: rtl/opr_pre_stage.sv
module opr_pre_stage
  import opr_micro_pkg::*;
(
  input  micro_t           ops,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             link_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             link_o
);
  logic [ACC_W-1:0] acc_cl, acc_iv;
  logic             link_cl, link_iv;
  logic [ACC_W:0]   sum;

  always_comb begin
    acc_cl  = ops.zero_acc  ? '0 : acc_i;
    link_cl = ops.zero_link ? 1'b0 : link_i;
    acc_iv  = ops.inv_acc  ? ~acc_cl  : acc_cl;
    link_iv = ops.inv_link ? ~link_cl : link_cl;
    sum     = {1'b0, acc_iv} + {{ACC_W{1'b0}}, ops.bump};
    acc_o   = sum[ACC_W-1:0];
    link_o  = link_iv ^ sum[ACC_W];
  end

  // wrap of the increment must flip the link (R3)
  always_comb begin
    if (ops.bump && acc_o == '0)
      p_wrap_flips_link_r3: assert (link_o != link_iv)
        else $error("wrap did not flip link");
  end
endmodule

// File: rtl/opr_shift_stage.sv
module opr_shift_stage
  import opr_micro_pkg::*;
(
  input  micro_t           ops,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             link_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             link_o
);
  localparam int STEPS = 2;

  logic [WIDE_W-1:0] rr [STEPS+1];
  logic [WIDE_W-1:0] rl [STEPS+1];
  logic [WIDE_W-1:0] result;
  logic [ACC_W-1:0]  swapped;
  logic              one_rot;

  assign rr[0] = {link_i, acc_i};
  assign rl[0] = {link_i, acc_i};

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    assign rr[s+1] = {rr[s][0], rr[s][WIDE_W-1:1]};
    assign rl[s+1] = {rl[s][WIDE_W-2:0], rl[s][WIDE_W-1]};
  end

  assign swapped = {acc_i[HALF_W-1:0], acc_i[ACC_W-1:HALF_W]};
  assign one_rot = ops.rot_r ^ ops.rot_l;

  always_comb begin
    result = {link_i, acc_i};
    if (one_rot && ops.rot_r)
      result = ops.pair ? rr[2] : rr[1];
    else if (one_rot && ops.rot_l)
      result = ops.pair ? rl[2] : rl[1];
    else if (ops.pair && !ops.rot_r && !ops.rot_l)
      result = {link_i, swapped};
    link_o = result[WIDE_W-1];
    acc_o  = result[ACC_W-1:0];
  end

  // rotate and swap only move bits (R4, R5)
  always_comb begin
    p_bits_conserved_r4: assert ($countones({link_o, acc_o}) == $countones({link_i, acc_i}))
      else $error("rotate/swap changed bit count");
  end
endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
  import opr_micro_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_instr,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic              in_link,
  output logic              done,
  output logic [ACC_W-1:0]  out_acc,
  output logic              out_link,
  output logic              rd_acc,
  output logic              wr_acc,
  output logic              rd_link,
  output logic              wr_link
);
  micro_t           ops;
  hazard_t          haz;
  logic [ACC_W-1:0] mid_acc, fin_acc;
  logic             mid_link, fin_link;

  opr_field_decode u_dec (
    .instr (in_instr),
    .ops   (ops),
    .haz   (haz)
  );

  opr_pre_stage u_pre (
    .ops    (ops),
    .acc_i  (in_acc),
    .link_i (in_link),
    .acc_o  (mid_acc),
    .link_o (mid_link)
  );

  opr_shift_stage u_shf (
    .ops    (ops),
    .acc_i  (mid_acc),
    .link_i (mid_link),
    .acc_o  (fin_acc),
    .link_o (fin_link)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      out_acc  <= '0;
      out_link <= 1'b0;
      rd_acc   <= 1'b0;
      wr_acc   <= 1'b0;
      rd_link  <= 1'b0;
      wr_link  <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        out_acc  <= fin_acc;
        out_link <= fin_link;
        rd_acc   <= haz.rd_acc;
        wr_acc   <= haz.wr_acc;
        rd_link  <= haz.rd_link;
        wr_link  <= haz.wr_link;
      end
    end
  end

  p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid));
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!done && $stable(out_acc) && $stable(out_link)));
  p_read_implies_write_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_acc |-> wr_acc) and (rd_link |-> wr_link));
  p_acc_untouched_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !haz.wr_acc) |=> out_acc == $past(in_acc));
  p_link_untouched_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !haz.wr_link) |=> out_link == $past(in_link));
endmodule

// File: tb/opr_micro_unit_tb.sv
module opr_micro_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_instr = '0;
  logic [11:0] in_acc = '0;
  logic        in_link = 1'b0;
  logic        done, out_link, rd_acc, wr_acc, rd_link, wr_link;
  logic [11:0] out_acc;

  int checks = 0;
  int errors = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;

  opr_micro_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_acc(in_acc), .in_link(in_link), .done(done), .out_acc(out_acc),
    .out_link(out_link), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .rd_link(rd_link), .wr_link(wr_link)
  );

  // arithmetic reference: returns {link, acc}
  function automatic logic [12:0] ref_op(input logic [11:0] ins, input logic [11:0] a, input logic l);
    int acc = a;
    int lk = l;
    int v;
    int n;
    if (ins[7]) acc = 0;
    if (ins[6]) lk = 0;
    if (ins[5]) acc = 4095 - acc;
    if (ins[4]) lk = 1 - lk;
    if (ins[0]) begin
      acc = (acc + 1) % 4096;
      if (acc == 0) lk = 1 - lk;
    end
    v = lk * 4096 + acc;
    n = ins[1] ? 2 : 1;
    if (ins[3] && !ins[2])
      for (int i = 0; i < n; i++) v = v / 2 + (v % 2) * 4096;
    else if (ins[2] && !ins[3])
      for (int i = 0; i < n; i++) v = (v * 2) % 8192 + v / 4096;
    else if (ins[1] && !ins[3] && !ins[2])
      v = (v / 4096) * 4096 + (acc % 64) * 64 + acc / 64;
    return v[12:0];
  endfunction

  function automatic logic [3:0] ref_haz(input logic [11:0] ins);
    logic ra, rl;
    ra = ins[5] | ins[3] | ins[2] | ins[1] | ins[0];
    rl = ins[4] | ins[3] | ins[2] | ins[0];
    return {ra, ra | ins[7], rl, rl | ins[6]};
  endfunction

  function automatic string tag_of(input logic [11:0] ins);
    if (ins[3] && ins[2]) return "R7";
    if (ins[1] && (ins[3] || ins[2])) return "R6";
    if (ins[1]) return "R5";
    if (ins[3] || ins[2]) return "R4";
    if (ins[0]) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", req, act, exp);
    end
  endtask

  // apply one op; results checked after the capturing edge
  task automatic run_op(input logic [11:0] ins, input logic [11:0] a, input logic l, input string req);
    logic [12:0] e;
    in_instr = ins; in_acc = a; in_link = l; in_valid = 1'b1;
    @(negedge clk);
    e = ref_op(ins, a, l);
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " result"}, {19'd0, out_link, out_acc}, {19'd0, e});
    check("R8 flags", {28'd0, rd_acc, wr_acc, rd_link, wr_link}, {28'd0, ref_haz(ins)});
  endtask

  initial begin
    #2_000_000;
    timed_out = 1;
  end

  initial begin : main
    logic [11:0] pats [8] = '{12'o0000, 12'o7777, 12'o4000, 12'o0001,
                               12'o5252, 12'o2525, 12'o7700, 12'o0077};
    logic [12:0] held;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {19'd0, done, out_link, out_acc, rd_acc, wr_acc, rd_link, wr_link}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {26'd0, done, out_link, rd_acc, wr_acc, rd_link, wr_link}, 32'd0);
    check("R1 acc after reset", {20'd0, out_acc}, 32'd0);

    // directed corner cases
    run_op(12'o0240, 12'o1234, 1'b0, "R2");  // zero then invert -> all ones
    check("R2 zero-then-invert", {20'd0, out_acc}, 32'o7777);
    run_op(12'o0001, 12'o7777, 1'b0, "R3");  // wrap flips link
    check("R3 wrap link", {31'd0, out_link}, 32'd1);
    run_op(12'o0010, 12'o0001, 1'b0, "R4");  // right: bit0 into link
    check("R4 rotate right", {19'd0, out_link, out_acc}, 32'o10000);
    run_op(12'o0004, 12'o4000, 1'b0, "R4");
    check("R4 rotate left", {19'd0, out_link, out_acc}, 32'o10000);
    run_op(12'o0002, 12'o0077, 1'b1, "R5");
    check("R5 swap", {19'd0, out_link, out_acc}, 32'o17700);
    run_op(12'o0012, 12'o0001, 1'b0, "R6");
    check("R6 double right", {19'd0, out_link, out_acc}, 32'o04000);
    run_op(12'o0016, 12'o1234, 1'b1, "R7");
    check("R7 both rotates", {19'd0, out_link, out_acc}, 32'o11234);
    run_op(12'o0057, 12'o0000, 1'b0, "R7");
    check("R7 side effects kept", {19'd0, out_link, out_acc}, 32'o10000);

    // R10: high bits ignored
    for (int h = 1; h < 16; h++) begin
      run_op({h[3:0], 8'o123}, 12'o3456, 1'b1, "R10");
    end

    // R9: hold while idle
    run_op(12'o0041, 12'o0100, 1'b0, "R9");
    held = {out_link, out_acc};
    in_valid = 1'b0; in_instr = 12'o0200; in_acc = 12'o5555; in_link = 1'b1;
    @(negedge clk);
    check("R9 done falls", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R9 hold", {19'd0, out_link, out_acc}, {19'd0, held});

    // exhaustive sweep of field bits
    for (int m = 0; m < 256; m++)
      for (int p = 0; p < 8; p++)
        for (int l = 0; l < 2; l++) begin
          logic [12:0] e;
          in_instr = {4'b0000, m[7:0]}; in_acc = pats[p]; in_link = l[0]; in_valid = 1'b1;
          @(negedge clk);
          e = ref_op(in_instr, pats[p], l[0]);
          check(tag_of(in_instr), {19'd0, out_link, out_acc}, {19'd0, e});
          check("R8 sweep flags", {28'd0, rd_acc, wr_acc, rd_link, wr_link}, {28'd0, ref_haz(in_instr)});
          if (timed_out) break;
        end
    in_valid = 1'b0;
    @(negedge clk);
    if (timed_out) check("watchdog", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule